// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter that sits on a microprocessor bus. A host starts a conversion by pulling chip-select and write low together. The block then runs a binary search. It drives a trial code to an external resistor-ladder DAC and reads back a one-bit comparator decision for every bit. When the search ends it stores the code and pulls an active-low interrupt line. The host collects the code with a read strobe, and that read releases the interrupt.

Timing is set by a free-running phase counter that is `SLOT_CLKS` clocks long. Each bit gets one full phase period, with the most significant bit first. A start request holds the search cleared for as long as both strobes stay low. The search starts at the next phase boundary after the request ends, so a start pulse can be as wide as the host likes. A new request during a search throws that search away.

The block can also run on its own. Tie chip-select low and feed the interrupt back to the write input; each completion then starts the next conversion. Nothing at the edge of the block can push back on it. The result latch keeps one code until the next completion overwrites it. This block has no valid/ready interface.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1 and `dac_code` is 0. No conversion begins, even with chip-select low, until a write strobe arrives.
- R2: In every clock in which `cs_n` and `wr_n` are both 0, the search is cleared: `dac_code` reads 0 from the next clock on, and no conversion proceeds.
- R3: After the start request ends, the trial code 0x80 (MSB only) appears between 1 and 8 clocks later. That moment falls on the block's 8-clock phase boundary, so every delay from 1 to 8 can occur.
- R4: Each bit owns an 8-clock slot, MSB first. At the start of slot k (k = 0 for the MSB), bit 7-k is set to 1 on top of the bits already decided. At the end of the slot the bit is kept if `cmp_hi` = 1 and cleared otherwise. `dac_code` does not change inside a slot.
- R5: The last decision comes 64 clocks after conversion start. The code is latched one clock later, and `intr_n` goes to 0 one clock after that, 66 clocks after 0x80 first appears.
- R6: With `cmp_hi` = 1 whenever the analog input is at or above `dac_code`, the final code equals the input value, for every value from 0 to 255.
- R7: A start request drives `intr_n` to 1 on the next clock.
- R8: A start request during a conversion abandons it. No interrupt comes from the abandoned search, and the following result reflects only the new conversion.
- R9: A read (`cs_n` = 0 and `rd_n` = 0) presents the latched code on `dout` and drives `intr_n` to 1 on the next clock. A read strobe with `cs_n` = 1 has no effect.
- R10: `dout` is 0 whenever no selected read is in progress.
- R11: With `cs_n` tied to 0 and `intr_n` fed back to `wr_n`, one external write pulse starts continuous operation. The interrupt then falls every 72 clocks, and each code is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (start) |
| rd_n | input | 1 | Active-low read strobe |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above the trial level |
| dac_code | output | NBITS | Trial code to the ladder DAC |
| dout | output | NBITS | Latched result during a selected read, else 0 |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
The assertions assume that the strobes and the comparator bit are synchronous to `clk`. They also assume `cmp_hi` is settled at each slot's closing edge, since a bit is decided only there. The bench meets these assumptions in two ways. It changes every strobe on the falling clock edge. It models the comparator as an ideal combinational compare of a held input value against `dac_code`, and that input is changed only outside a running search or at an interrupt edge. In free-running mode `wr_n` is driven by the block's own registered `intr_n`, so it stays synchronous too.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Control handed from the start/phase unit to the search unit.
  typedef struct packed {
    logic clr;       // start request present: clear and hold
    logic go;        // begin a new search on this edge
    logic slot_end;  // last clock of the current bit slot
  } seq_ctl_t;

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync
  import sar_pkg::*;
#(
  parameter int SLOT_CLKS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  output seq_ctl_t ctl
);
  localparam int PHW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [PHW-1:0] PH_LAST = PHW'(SLOT_CLKS - 1);

  logic [PHW-1:0] phase;
  logic           armed;
  logic           ph_end;

  assign ph_end = (phase == PH_LAST);

  // Free-running phase: slot boundaries and release points share it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      armed <= 1'b0;
    end else begin
      phase <= ph_end ? '0 : phase + 1'b1;
      if (req)
        armed <= 1'b1;
      else if (ph_end)
        armed <= 1'b0;
    end
  end

  assign ctl.clr      = req;
  assign ctl.go       = armed & ~req & ph_end;
  assign ctl.slot_end = ph_end;

endmodule

// File: rtl/sar_search.sv
module sar_search
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_ctl_t         ctl,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] code,
  output logic             done
);
  localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDXW-1:0] TOP = IDXW'(NBITS - 1);

  logic            active;
  logic [IDXW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= '0;
      active <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.clr) begin
        code   <= '0;
        active <= 1'b0;
      end else if (ctl.go) begin
        code      <= '0;
        code[TOP] <= 1'b1;
        idx       <= TOP;
        active    <= 1'b1;
      end else if (active && ctl.slot_end) begin
        if (!cmp_hi)
          code[idx] <= 1'b0;
        if (idx == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          code[idx - 1'b1] <= 1'b1;
          idx              <= idx - 1'b1;
        end
      end
    end
  end

  // R4: the trial code only moves at a slot boundary or on a clear
  a_r4_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.slot_end && !ctl.clr) |=> $stable(code));

  // R5: completion is a single-clock event
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [NBITS-1:0] code,
  input  logic             req,
  input  logic             rd_sel,
  output logic [NBITS-1:0] result,
  output logic             intr_n
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      pend   <= 1'b0;
      intr_n <= 1'b1;
    end else begin
      if (done)
        result <= code;
      if (req) begin
        intr_n <= 1'b1;
        pend   <= 1'b0;
      end else begin
        pend <= done;
        if (pend)
          intr_n <= 1'b0;
        else if (rd_sel)
          intr_n <= 1'b1;
      end
    end
  end

  // R5: the latch is already settled when the interrupt falls
  a_r5_latch_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> ($stable(result) && $past(done, 2)));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS     = 8,
  parameter int SLOT_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] dout,
  output logic             intr_n
);
  logic             req;
  logic             rd_sel;
  logic             done;
  logic [NBITS-1:0] result;
  seq_ctl_t         ctl;

  assign req    = ~cs_n & ~wr_n;
  assign rd_sel = ~cs_n & ~rd_n;

  sar_start_sync #(.SLOT_CLKS(SLOT_CLKS)) u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .ctl   (ctl)
  );

  sar_search #(.NBITS(NBITS)) u_search (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .cmp_hi (cmp_hi),
    .code   (dac_code),
    .done   (done)
  );

  sar_result #(.NBITS(NBITS)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .code   (dac_code),
    .req    (req),
    .rd_sel (rd_sel),
    .result (result),
    .intr_n (intr_n)
  );

  assign dout = rd_sel ? result : '0;

  // R2: a held start request keeps the trial code cleared
  a_r2_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (dac_code == '0));

  // R7: a start request releases the interrupt
  a_r7_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> intr_n);

  // R9: the interrupt only rises after a start request or a selected read
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_n) |-> ($past(req) || $past(rd_sel)));

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cs_drv = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, kick_n = 1'b1, fr = 1'b0;
  logic [7:0] vin = 8'd0;
  logic       cs_n, wr_n, cmp_hi, intr_n;
  logic [7:0] dac_code, dout;

  assign cs_n   = fr ? 1'b0 : cs_drv;
  assign wr_n   = fr ? (intr_n & kick_n) : wr_drv;
  assign cmp_hi = (vin >= dac_code);

  sar_conv_ctrl #(.NBITS(8), .SLOT_CLKS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .dout(dout), .intr_n(intr_n)
  );

  int       errors = 0;
  int       checks = 0;
  bit [7:0] dseen  = 8'd0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_pulse(input int width, output int d);
    cs_drv = 1'b0; wr_drv = 1'b0;
    for (int i = 0; i < width; i++) begin
      tick();
      chk(dac_code == 8'd0, "R2 code held clear", dac_code, 0);
      chk(intr_n == 1'b1, "R7 start releases interrupt", intr_n, 1);
    end
    wr_drv = 1'b1; cs_drv = 1'b1;
    d = 0;
    while (dac_code != 8'h80 && d < 20) begin
      tick();
      d++;
    end
  endtask

  task automatic convert(input logic [7:0] v, input int width);
    int d;
    int off;
    int expv;
    vin = v;
    start_pulse(width, d);
    chk(d >= 1 && d <= 8, "R3 start delay", d, 1);
    if (d >= 1 && d <= 8) dseen[d-1] = 1'b1;
    off = 0;
    for (int k = 0; k < 8; k++) begin
      while (off < 8*k + 4) begin tick(); off++; end
      expv = (int'(v) & (~(255 >> k) & 255)) | (128 >> k);
      chk(int'(dac_code) == expv, "R4 trial code in slot", dac_code, expv);
      chk(intr_n == 1'b1, "R8 no interrupt during search", intr_n, 1);
    end
    while (off < 65) begin tick(); off++; end
    chk(intr_n == 1'b1, "R5 interrupt not early", intr_n, 1);
    tick();
    chk(intr_n == 1'b0, "R5 interrupt at 66 clocks", intr_n, 0);
    chk(dac_code == v, "R6 final code", dac_code, v);
    if (!v[0]) begin
      chk(dout == 8'd0, "R10 dout idle", dout, 0);
      rd_n = 1'b0; cs_drv = 1'b0;
      #1;
      chk(dout == v, "R9 read data", dout, v);
      tick();
      chk(intr_n == 1'b1, "R9 read releases interrupt", intr_n, 1);
      rd_n = 1'b1; cs_drv = 1'b1;
      #1;
      chk(dout == 8'd0, "R10 dout after read", dout, 0);
    end else begin
      rd_n = 1'b0;
      #1;
      chk(dout == 8'd0, "R10 unselected read output", dout, 0);
      tick();
      chk(intr_n == 1'b0, "R9 unselected read ignored", intr_n, 0);
      rd_n = 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int d;
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(intr_n == 1'b1, "R1 reset interrupt", intr_n, 1);
    chk(dac_code == 8'd0, "R1 reset code", dac_code, 0);
    chk(dout == 8'd0, "R10 reset dout", dout, 0);
    cs_drv = 1'b0;
    repeat (100) tick();
    chk(intr_n == 1'b1 && dac_code == 8'd0, "R1 no start without write",
        dac_code, 0);
    cs_drv = 1'b1;

    for (int v = 0; v < 256; v++) convert(8'(v), 1 + (v % 13));
    chk(dseen == 8'hFF, "R3 every delay 1..8 seen", dseen, 255);

    // R8: abort a search mid-way, then convert a new value
    vin = 8'hA5;
    start_pulse(3, d);
    repeat (20) tick();
    convert(8'h3C, 5);

    // R11: free-running loop
    fr = 1'b1;
    vin = 8'h5A;
    kick_n = 1'b0;
    tick();
    kick_n = 1'b1;
    n = 0;
    while (intr_n != 1'b0 && n < 200) begin tick(); n++; end
    chk(intr_n == 1'b0, "R11 first free-run completion", intr_n, 0);
    chk(dac_code == 8'h5A, "R11 first free-run code", dac_code, 8'h5A);
    for (int r = 0; r < 4; r++) begin
      vin = 8'(8'h21 * (r + 2));
      n = 0;
      while (intr_n == 1'b0 && n < 300) begin tick(); n++; end
      while (intr_n == 1'b1 && n < 300) begin tick(); n++; end
      chk(n == 72, "R11 free-run period", n, 72);
      chk(dac_code == vin, "R11 free-run code", dac_code, vin);
    end
    fr = 1'b0;
    finish_run();
  end
endmodule